// File: doc/BRIEF.md
# Page Buffer Write Controller

This block models the page-oriented write path of a byte-wide nonvolatile memory as synchronous logic. A host issues single-cycle byte-load strobes, each carrying an 18-bit address and a data byte. The low seven address bits pick one of 128 slots in a page buffer. The upper eleven bits name the page that will receive the buffer. A strobe is taken only while the external "write permitted" qualifier is high, so the command unlock logic upstream decides whether loading may happen at all.

Every accepted strobe restarts an inactivity timer. When the timer runs out with no new strobe, the load window closes and an internally timed program cycle begins. The busy flag stays high for the whole cycle, and the cycle cannot be stopped. At its last cycle the complete 128-byte page goes into the array in one step. Slots loaded in the window carry their latest data, and every other slot is written as FFh. The target page is the page of the last byte loaded. Reads to the array have one cycle of latency. While busy is high, a read returns a progress status byte in place of array data.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, busy is 0 and rd_data is 00h, and no buffer slot counts as loaded.
- R2: A strobe with wr_ok high stores ld_data in buffer slot ld_addr[6:0] and marks that slot loaded.
- R3: A strobe with wr_ok low changes nothing: busy stays 0 and no array byte changes.
- R4: busy rises exactly LOAD_TIMEOUT clock cycles after the clock edge that takes the last accepted strobe. Each accepted strobe restarts this count.
- R5: A second strobe to a slot already loaded in the same window replaces that slot's data.
- R6: The committed page is ld_addr[17:7] of the last accepted strobe, and this holds for every loaded slot.
- R7: A slot not loaded in the window is committed as FFh.
- R8: busy stays high for exactly WRITE_CYCLES cycles, then falls. All 128 bytes of the page become readable with their new values at the same point.
- R9: Strobes that arrive while busy is high are ignored. They neither alter the buffer nor open a new window.
- R10: A read taken while busy is high returns a status byte. Bit 7 is the inverse of bit 7 of the last accepted data byte. Bit 6 is 1 on the first such read of a program cycle and flips on each later read. Bits 5..0 are 0.
- R11: When idle or loading, a read with rd_en high returns the array byte at rd_addr one cycle later. The array starts with every byte at FFh, and rd_data holds its value when rd_en is low.
- R12: The loaded-slot record is cleared when a program cycle completes, so the next page write commits FFh in every slot that the new window did not load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | Single-cycle byte-load strobe |
| wr_ok | input | 1 | Write-permitted qualifier from the unlock decoder |
| ld_addr | input | ADDR_W | Load address: page in [17:7], slot in [6:0] |
| ld_data | input | DATA_W | Byte to load |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data or status byte |
| busy | output | 1 | High during the internal program cycle |

## Verification
The assertions assume that ld_stb, wr_ok and rd_en are synchronous single-bit levels sampled at each rising edge. They also assume that both timing parameters are at least one, which keeps the shared counter below its active limit. The bench changes every input only on falling clock edges and keeps each load strobe one cycle wide. It shortens the two timing windows so that many windows fit into one run. It places strobes just inside and just outside the inactivity limit, so that the restart behaviour and the exact start of the program cycle are both exercised.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pwc_state_e;

  function automatic int unsigned pwc_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pwc_timer.sv
module pwc_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  assign done = run && (cnt_q == (limit - ONE));

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + ONE;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) run |-> (cnt_q < limit)); // R4
  AST_LIMIT_NONZERO: assert property (@(posedge clk) disable iff (rst) run |-> (limit != '0)); // R8
endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFFS_W = 7,
  parameter int unsigned PAGE_W = 11
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [OFFS_W-1:0]             wr_off,
  input  logic [PAGE_W-1:0]             wr_page,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          clr,
  input  logic                          hold,
  output logic [(1<<OFFS_W)*DATA_W-1:0] row,
  output logic [PAGE_W-1:0]             tgt_page,
  output logic                          last_msb
);
  localparam int unsigned DEPTH = 1 << OFFS_W;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [PAGE_W-1:0] page_q;
  logic              msb_q;

  always_ff @(posedge clk) begin
    if (we) slot_q[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      page_q  <= '0;
      msb_q   <= 1'b0;
    end else begin
      if (clr) valid_q <= '0;
      if (we) begin
        valid_q[wr_off] <= 1'b1;
        page_q          <= wr_page;
        msb_q           <= wr_data[DATA_W-1];
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_merge
    assign row[i*DATA_W +: DATA_W] = valid_q[i] ? slot_q[i] : {DATA_W{1'b1}};
  end

  assign tgt_page = page_q;
  assign last_msb = msb_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) (hold && !clr) |=> ($stable(valid_q) && $stable(page_q))); // R9
  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst) clr |=> (valid_q == '0)); // R12
  AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (rst) we |=> valid_q[$past(wr_off)]); // R2
endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFFS_W = 7,
  parameter int unsigned PAGE_W = 11
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [PAGE_W-1:0]             wr_page,
  input  logic [(1<<OFFS_W)*DATA_W-1:0] wr_row,
  input  logic                          rd_en,
  input  logic [PAGE_W-1:0]             rd_page,
  input  logic [OFFS_W-1:0]             rd_off,
  input  logic                          stat_sel,
  input  logic [DATA_W-1:0]             stat_byte,
  output logic [DATA_W-1:0]             rd_data
);
  localparam int unsigned ROW_W  = (1 << OFFS_W) * DATA_W;
  localparam int unsigned NPAGES = 1 << PAGE_W;

  logic [ROW_W-1:0]  mem [NPAGES];
  logic [DATA_W-1:0] rd_q;

  initial begin
    for (int p = 0; p < NPAGES; p++) mem[p] = '1;
  end

  always @(posedge clk) begin
    if (we) mem[wr_page] <= wr_row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      if (stat_sel) rd_q <= stat_byte;
      else          rd_q <= mem[rd_page][rd_off*DATA_W +: DATA_W];
    end
  end

  assign rd_data = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !rd_en |=> $stable(rd_q)); // R11
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 18,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned OFFS_W       = 7,
  parameter int unsigned LOAD_TIMEOUT = 20000,
  parameter int unsigned WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_stb,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int unsigned PAGE_W  = ADDR_W - OFFS_W;
  localparam int unsigned ROW_W   = (1 << OFFS_W) * DATA_W;
  localparam int unsigned CNT_MAX = pwc_max(LOAD_TIMEOUT, WRITE_CYCLES);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LD_LIM = CNT_W'(LOAD_TIMEOUT);
  localparam logic [CNT_W-1:0] WR_LIM = CNT_W'(WRITE_CYCLES);

  pwc_state_e        state_q;
  logic              busy_q;
  logic              tog_q;
  logic              accept;
  logic              load_end;
  logic              prog_done;
  logic              tmr_run;
  logic              tmr_clr;
  logic              tmr_done;
  logic [CNT_W-1:0]  tmr_lim;
  logic [ROW_W-1:0]  commit_row;
  logic [PAGE_W-1:0] tgt_page;
  logic              last_msb;
  logic [DATA_W-1:0] stat_byte;

  assign accept    = ld_stb && wr_ok && (state_q != ST_PROG);
  assign tmr_run   = (state_q != ST_IDLE);
  assign tmr_lim   = (state_q == ST_PROG) ? WR_LIM : LD_LIM;
  assign load_end  = (state_q == ST_LOAD) && tmr_done && !accept;
  assign prog_done = (state_q == ST_PROG) && tmr_done;
  assign tmr_clr   = accept || load_end || prog_done;
  assign stat_byte = {~last_msb, tog_q, {(DATA_W-2){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) state_q <= ST_LOAD;
        ST_LOAD: if (load_end) begin
          state_q <= ST_PROG;
          busy_q  <= 1'b1;
        end
        ST_PROG: if (prog_done) begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  tog_q <= 1'b1;
    else if (load_end)        tog_q <= 1'b1;
    else if (rd_en && busy_q) tog_q <= ~tog_q;
  end

  pwc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .limit (tmr_lim),
    .done  (tmr_done)
  );

  pwc_page_buf #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .PAGE_W(PAGE_W)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .we       (accept),
    .wr_off   (ld_addr[OFFS_W-1:0]),
    .wr_page  (ld_addr[ADDR_W-1:OFFS_W]),
    .wr_data  (ld_data),
    .clr      (prog_done),
    .hold     (busy_q),
    .row      (commit_row),
    .tgt_page (tgt_page),
    .last_msb (last_msb)
  );

  pwc_array #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .PAGE_W(PAGE_W)) u_array (
    .clk       (clk),
    .rst       (rst),
    .we        (prog_done),
    .wr_page   (tgt_page),
    .wr_row    (commit_row),
    .rd_en     (rd_en),
    .rd_page   (rd_addr[ADDR_W-1:OFFS_W]),
    .rd_off    (rd_addr[OFFS_W-1:0]),
    .stat_sel  (busy_q),
    .stat_byte (stat_byte),
    .rd_data   (rd_data)
  );

  assign busy = busy_q;

  AST_PROG_RUNS: assert property (@(posedge clk) disable iff (rst) (busy_q && !prog_done) |=> busy_q); // R8
  AST_COMMIT_DROPS: assert property (@(posedge clk) disable iff (rst) prog_done |=> (!busy_q && state_q == ST_IDLE)); // R8
  AST_PROG_ENTRY: assert property (@(posedge clk) disable iff (rst) $rose(busy_q) |-> ($past(state_q) == ST_LOAD)); // R4
  AST_DENIED_IDLE: assert property (@(posedge clk) disable iff (rst) (state_q == ST_IDLE && !wr_ok) |=> (state_q == ST_IDLE)); // R3
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst) busy_q |-> (state_q == ST_PROG)); // R9
endmodule

// File: tb/sim_page_write_ctrl.sv
module sim_page_write_ctrl;
  localparam int LT = 20;
  localparam int WC = 50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_stb = 1'b0;
  logic        wr_ok = 1'b1;
  logic [17:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        rd_en = 1'b0;
  logic [17:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;

  page_write_ctrl #(
    .ADDR_W(18), .DATA_W(8), .OFFS_W(7), .LOAD_TIMEOUT(LT), .WRITE_CYCLES(WC)
  ) u0 (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .wr_ok(wr_ok), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;

  rd_item_t   sb_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  logic [7:0] model [int];
  logic [7:0] bbuf [128];
  bit         bval [128];
  int         bpage = 0;
  logic [7:0] blast = '0;
  bit         tgl_exp = 1'b1;
  int         run_len = 0;
  int         last_len = 0;
  bit         prev_busy = 1'b0;

  function automatic logic [7:0] mem_exp(input int a);
    return model.exists(a) ? model[a] : 8'hFF;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as read results appear
  always @(posedge clk) begin
    if (rd_en) begin
      #1;
      if (sb_q.size() == 0) begin
        check8("R11 unexpected read", rd_data, 8'h00);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check8(it.tag, rd_data, it.exp);
      end
    end
  end

  // busy pulse length meter
  always @(negedge clk) begin
    if (busy) run_len++;
    else if (prev_busy) begin
      last_len = run_len;
      run_len = 0;
    end
    prev_busy = busy;
  end

  task automatic rd(input int pg, input int off, input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = 18'((pg << 7) | off);
    sb_q.push_back('{mem_exp(pg*128 + off), tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_status(input string tag);
    @(negedge clk);
    check8({tag, " busy"}, {7'd0, busy}, 8'd1);
    rd_en = 1'b1;
    sb_q.push_back('{{~blast[7], tgl_exp, 6'b0}, tag});
    tgl_exp = ~tgl_exp;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ld(input int pg, input int off, input logic [7:0] d, input bit ok);
    @(negedge clk);
    ld_stb = 1'b1;
    wr_ok = ok;
    ld_addr = 18'((pg << 7) | off);
    ld_data = d;
    if (ok && !busy) begin
      bbuf[off] = d;
      bval[off] = 1'b1;
      bpage = pg;
      blast = d;
    end
    @(negedge clk);
    ld_stb = 1'b0;
    wr_ok = 1'b1;
  endtask

  task automatic wait_commit(input string tag);
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    check8({tag, " busy length"}, 8'(last_len), 8'(WC));
    for (int i = 0; i < 128; i++) begin
      model[bpage*128 + i] = bval[i] ? bbuf[i] : 8'hFF;
      bval[i] = 1'b0;
    end
    tgl_exp = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) bval[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check8("R1 busy after reset", {7'd0, busy}, 8'd0);
    check8("R1 rd_data after reset", rd_data, 8'h00);
    rd(0, 0, "R11 erased array");

    // page 2: several slots, one overwritten
    ld(2, 0, 8'h11, 1'b1);
    ld(2, 5, 8'h22, 1'b1);
    ld(2, 127, 8'h83, 1'b1);
    ld(2, 5, 8'h66, 1'b1);
    repeat (LT - 1) @(negedge clk);
    check8("R4 busy just before timeout", {7'd0, busy}, 8'd0);
    @(negedge clk);
    check8("R4 busy at timeout", {7'd0, busy}, 8'd1);
    rd_status("R10 status first read");
    rd_status("R10 status second read");
    ld(2, 1, 8'h77, 1'b1);
    rd_status("R10 status third read");
    wait_commit("R8 page 2");
    rd(2, 0, "R2 slot 0");
    rd(2, 5, "R5 overwritten slot");
    rd(2, 127, "R2 top slot");
    rd(2, 1, "R9 load during busy ignored");
    rd(2, 64, "R7 unloaded slot");
    repeat (LT + 3) @(negedge clk);
    check8("R9 no window after busy load", {7'd0, busy}, 8'd0);

    // page follows last byte
    ld(3, 10, 8'hA5, 1'b1);
    ld(4, 20, 8'h3C, 1'b1);
    while (!busy) @(negedge clk);
    rd_status("R10 status msb inverse");
    wait_commit("R8 page 4");
    rd(4, 10, "R6 early byte on last page");
    rd(4, 20, "R6 last byte");
    rd(3, 10, "R6 first page untouched");

    // denied load
    ld(5, 0, 8'h12, 1'b0);
    repeat (LT + 5) @(negedge clk);
    check8("R3 denied load no busy", {7'd0, busy}, 8'd0);
    rd(5, 0, "R3 denied load no data");

    // restart of the inactivity window
    for (int k = 0; k < 4; k++) begin
      check8("R4 window kept open", {7'd0, busy}, 8'd0);
      ld(6, k, 8'(8'h40 + k), 1'b1);
      repeat (LT - 3) @(negedge clk);
    end
    wait_commit("R8 page 6");
    rd(6, 3, "R4 last restarted byte");
    rd(6, 0, "R4 first restarted byte");

    // bitmap cleared after commit
    ld(2, 7, 8'h01, 1'b1);
    wait_commit("R8 page 2 again");
    rd(2, 0, "R12 old slot now erased");
    rd(2, 7, "R12 new slot");
    rd(2, 127, "R12 old top slot erased");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 pending reads actual=%0d expected=0", sb_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule